// File: doc/BRIEF.md
# PWM Reload Flag and Interrupt Controller

This block keeps the status flag that marks the start of each reload cycle of a motor-control PWM. It also drives the PWM interrupt request that comes from that flag. The PWM counter sends a one-cycle reload strobe, and the flag sets on every such strobe. The load-ok bit has no effect on this.

Software clears the flag in two steps. First it reads the control register while the flag is set, which arms the clear. Then it writes zero to the flag bit. If a reload arrives between the read and the write, the pending clear is cancelled and the flag stays set.

The interrupt request is the flag gated by the interrupt-enable bit, held in a register. Clearing the flag drops a pending PWM interrupt. A separate fault interrupt request passes through on its own register and is never changed by a clear.

Top module: `pwm_reload_flag`

## Requirements
- R1: The flag output reads 1 on the first clock edge that samples `reload_stb` high, whatever the value of `load_ok`.
- R2: The flag clears on the edge that samples a valid zero write. A valid zero write is `reg_wr` high with bit 4 of `wr_data` at 0, made after an arming read. An arming read is `reg_rd` high while the flag is 1.
- R3: A zero write with no arming read before it leaves the flag at 1. A read made while the flag is 0 does not arm a clear.
- R4: A reload that lands after the arming read and before the zero write cancels the armed clear. The zero write that follows leaves the flag at 1, and a new arming read is needed.
- R5: A write with bit 4 of `wr_data` at 1 never sets the flag and never clears it. It does not cancel an armed clear.
- R6: When a reload and a valid zero write are sampled on the same edge, the flag stays 1.
- R7: `pwm_irq` is registered. After each edge it equals the new flag value ANDed with `irq_en` as sampled on that edge. With `irq_en` at 0, `pwm_irq` stays 0.
- R8: Clearing the flag drops `pwm_irq` on the same edge. `fault_irq` follows `fault_req` one cycle later and is never changed by a flag clear.
- R9: `pwm_irq` is raised and held in the same way whether `load_ok` is 0 or 1.
- R10: A synchronous active-high reset clears the flag, the armed state, `pwm_irq` and `fault_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reload_stb | input | 1 | One-cycle strobe from the PWM counter at the start of a reload cycle |
| reg_rd | input | 1 | Read strobe for the control register |
| reg_wr | input | 1 | Write strobe for the control register |
| wr_data | input | DATA_W (8) | Write data. Bit FLAG_BIT (4) is the flag bit |
| irq_en | input | 1 | PWM interrupt enable |
| load_ok | input | 1 | Load-ok bit. It has no effect on the flag or the interrupt |
| fault_req | input | 1 | Fault interrupt request |
| flag | output | 1 | Reload flag value as software reads it |
| pwm_irq | output | 1 | PWM interrupt request |
| fault_irq | output | 1 | Registered fault interrupt request |

## Verification
Some properties can be checked on every cycle, and the assertions cover them:
- a reload always sets the flag;
- the flag can only fall on an armed zero write that has no reload beside it;
- the flag never rises without a reload;
- the interrupt line matches the flag gated by the sampled enable;
- the fault line matches its input one cycle earlier.

Other behaviour depends on a sequence of steps, and only the directed scenarios show it. These are the arm-then-clear handshake, the cancellation of an armed clear by a reload that lands mid-handshake, a zero write with no arming read, a write of one that does not cancel arming, and the independence from load-ok.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    localparam int DATA_W_DEF   = 8;
    localparam int FLAG_BIT_DEF = 4;

    typedef struct packed {
        logic reload;    // new reload cycle begins
        logic arm_rd;    // read of the control register while the flag is set
        logic zero_wr;   // write with the flag bit at zero
    } flag_evt_t;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;

    function automatic flag_state_t next_state(flag_state_t cur, flag_evt_t ev);
        flag_state_t nx;
        nx = cur;
        if (ev.reload) begin
            nx.flag  = 1'b1;
            nx.armed = 1'b0;
        end else if (ev.zero_wr) begin
            if (cur.armed) nx.flag = 1'b0;
            nx.armed = 1'b0;
        end else if (ev.arm_rd) begin
            nx.armed = 1'b1;
        end
        return nx;
    endfunction

endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
    import pwm_reload_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int FLAG_BIT = FLAG_BIT_DEF
) (
    input  logic              reload_stb,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_now,
    output flag_evt_t         evt
);
    always_comb begin
        evt.reload  = reload_stb;
        evt.arm_rd  = reg_rd & flag_now;
        evt.zero_wr = reg_wr & ~wr_data[FLAG_BIT];
    end
endmodule

// File: rtl/pwm_flag_state.sv
module pwm_flag_state
    import pwm_reload_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  flag_evt_t   evt,
    output flag_state_t st_q,
    output flag_state_t st_d
);
    always_comb st_d = next_state(st_q, evt);

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwm_irq_stage.sv
module pwm_irq_stage (
    input  logic clk,
    input  logic rst,
    input  logic flag_d,
    input  logic irq_en,
    input  logic fault_req,
    output logic pwm_irq,
    output logic fault_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_irq   <= 1'b0;
            fault_irq <= 1'b0;
        end else begin
            pwm_irq   <= flag_d & irq_en;
            fault_irq <= fault_req;
        end
    end
endmodule

// File: rtl/pwm_reload_flag.sv
module pwm_reload_flag
    import pwm_reload_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int FLAG_BIT = FLAG_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_stb,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              load_ok,
    input  logic              fault_req,
    output logic              flag,
    output logic              pwm_irq,
    output logic              fault_irq
);
    flag_evt_t   evt;
    flag_state_t st_q;
    flag_state_t st_d;
    logic        armed;

    // Load-ok is accepted at the edge but never steers the flag or the interrupt.
    logic unused_bits;
    assign unused_bits = ^{load_ok, wr_data};

    pwm_bus_decode #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_dec (
        .reload_stb (reload_stb),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .wr_data    (wr_data),
        .flag_now   (st_q.flag),
        .evt        (evt)
    );

    pwm_flag_state u_state (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .st_q (st_q),
        .st_d (st_d)
    );

    pwm_irq_stage u_irq (
        .clk       (clk),
        .rst       (rst),
        .flag_d    (st_d.flag),
        .irq_en    (irq_en),
        .fault_req (fault_req),
        .pwm_irq   (pwm_irq),
        .fault_irq (fault_irq)
    );

    assign flag  = st_q.flag;
    assign armed = st_q.armed;
endmodule

// File: rtl/pwm_reload_flag_chk.sv
module pwm_reload_flag_chk #(
    parameter int DATA_W   = 8,
    parameter int FLAG_BIT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reload_stb,
    input logic              reg_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_en,
    input logic              fault_req,
    input logic              flag,
    input logic              armed,
    input logic              pwm_irq,
    input logic              fault_irq
);
    logic zero_wr;
    assign zero_wr = reg_wr & ~wr_data[FLAG_BIT];

    // R1 / R6: any reload leaves the flag set
    assert_reload_sets_R1: assert property (@(posedge clk) disable iff (rst)
        reload_stb |=> flag);

    // R2 / R3 / R4: the flag falls only on an armed zero write with no reload
    assert_clear_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (flag && !(zero_wr && armed && !reload_stb)) |=> flag);

    // R5: the flag never rises without a reload
    assert_no_set_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!flag && !reload_stb) |=> !flag);

    // R4: a reload always drops the armed state
    assert_reload_disarms_R4: assert property (@(posedge clk) disable iff (rst)
        reload_stb |=> !armed);

    // R7: interrupt equals flag gated by the enable sampled on the last edge
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwm_irq == (flag && $past(irq_en))));

    // R8: fault line follows its own input only
    assert_fault_pass_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fault_irq == $past(fault_req)));
endmodule

bind pwm_reload_flag pwm_reload_flag_chk #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reload_stb (reload_stb),
    .reg_wr     (reg_wr),
    .wr_data    (wr_data),
    .irq_en     (irq_en),
    .fault_req  (fault_req),
    .flag       (flag),
    .armed      (armed),
    .pwm_irq    (pwm_irq),
    .fault_irq  (fault_irq)
);

// File: tb/tb_pwm_reload_flag.sv
module tb_pwm_reload_flag;
    logic       clk = 1'b0;
    logic       rst;
    logic       reload_stb;
    logic       reg_rd;
    logic       reg_wr;
    logic [7:0] wr_data;
    logic       irq_en;
    logic       load_ok;
    logic       fault_req;
    logic       flag;
    logic       pwm_irq;
    logic       fault_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_reload_flag dut (
        .clk(clk), .rst(rst), .reload_stb(reload_stb), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .wr_data(wr_data), .irq_en(irq_en), .load_ok(load_ok),
        .fault_req(fault_req), .flag(flag), .pwm_irq(pwm_irq), .fault_irq(fault_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one clock: inputs are set 2 ns after an edge, results read 2 ns after the next
    task automatic tick();
        @(posedge clk);
        #2;
        reload_stb = 1'b0;
        reg_rd     = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic do_reload();      reload_stb = 1'b1; tick(); endtask
    task automatic do_read();        reg_rd = 1'b1; tick(); endtask
    task automatic do_write(input logic bitv);
        reg_wr = 1'b1; wr_data = 8'hEF | (8'(bitv) << 4); tick();
    endtask

    task automatic reset_dut();
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    endtask

    task automatic t_reset();
        fault_req = 1'b1; irq_en = 1'b1;
        rst = 1'b1; do_reload();
        check("R10 flag", flag, 1'b0);
        check("R10 irq", pwm_irq, 1'b0);
        check("R10 fault", fault_irq, 1'b0);
        rst = 1'b0; fault_req = 1'b0; tick();
        // a zero write right after reset must not clear a later-set flag (not armed)
        do_reload(); do_write(1'b0);
        check("R10 armed cleared", flag, 1'b1);
    endtask

    task automatic t_set_and_clear();
        reset_dut(); irq_en = 1'b1; load_ok = 1'b0;
        do_reload();
        check("R1 set with load_ok 0", flag, 1'b1);
        check("R7 irq with flag", pwm_irq, 1'b1);
        check("R9 irq with load_ok 0", pwm_irq, 1'b1);
        do_read(); do_write(1'b0);
        check("R2 cleared", flag, 1'b0);
        check("R8 irq dropped", pwm_irq, 1'b0);
        load_ok = 1'b1; do_reload();
        check("R1 set with load_ok 1", flag, 1'b1);
        check("R9 irq with load_ok 1", pwm_irq, 1'b1);
        load_ok = 1'b0;
    endtask

    task automatic t_no_arm();
        reset_dut();
        do_read();               // read while clear: no arming
        do_reload();
        do_write(1'b0);
        check("R3 read while clear does not arm", flag, 1'b1);
        do_write(1'b0);
        check("R3 unarmed zero write", flag, 1'b1);
    endtask

    task automatic t_reload_cancel();
        reset_dut();
        do_reload(); do_read(); do_reload(); do_write(1'b0);
        check("R4 cancelled clear", flag, 1'b1);
        do_read(); do_write(1'b0);
        check("R4 new arm clears", flag, 1'b0);
    endtask

    task automatic t_write_one();
        reset_dut();
        do_write(1'b1);
        check("R5 write 1 no set", flag, 1'b0);
        do_reload(); do_read(); do_write(1'b1);
        check("R5 write 1 no clear", flag, 1'b1);
        do_write(1'b0);
        check("R5 arming kept after write 1", flag, 1'b0);
    endtask

    task automatic t_same_cycle();
        reset_dut();
        do_reload(); do_read();
        reload_stb = 1'b1; reg_wr = 1'b1; wr_data = 8'h00; tick();
        check("R6 reload wins", flag, 1'b1);
    endtask

    task automatic t_enable_fault();
        reset_dut(); irq_en = 1'b0;
        do_reload();
        check("R7 flag set", flag, 1'b1);
        check("R7 irq blocked", pwm_irq, 1'b0);
        irq_en = 1'b1; tick();
        check("R7 irq after enable", pwm_irq, 1'b1);
        fault_req = 1'b1; tick();
        check("R8 fault follows", fault_irq, 1'b1);
        do_read(); do_write(1'b0);
        check("R8 flag cleared", flag, 1'b0);
        check("R8 irq cleared", pwm_irq, 1'b0);
        check("R8 fault kept", fault_irq, 1'b1);
        fault_req = 1'b0; tick();
        check("R8 fault low", fault_irq, 1'b0);
    endtask

    initial begin
        rst = 1'b1; reload_stb = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        wr_data = 8'h00; irq_en = 1'b0; load_ok = 1'b0; fault_req = 1'b0;
        #3;
        t_reset();
        t_set_and_clear();
        t_no_arm();
        t_reload_cancel();
        t_write_one();
        t_same_cycle();
        t_enable_fault();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule